// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This block resolves one branch instruction per valid strobe. It receives a 32-bit instruction word, the current program counter, the 32-bit condition register, the count register and a register holding an indirect target. From these it identifies the branch form and sign-extends the displacement. It runs the optional count test and the optional condition-bit test. It then reports whether the branch is taken, the address of the next instruction, and a decremented count value with its write enable.

The instruction layout is fixed. The primary opcode sits in bits 31:26. Opcode 18 is the unconditional form, opcode 16 the conditional immediate form and opcode 19 the conditional register-target form. Bit 1 selects an absolute target in the immediate forms. Bit 0 is ignored. In the conditional forms, the 5-bit branch options field is in bits 25:21 and the condition bit index is in bits 20:16. The unconditional displacement is in bits 25:2, and the conditional displacement is in bits 15:2. The register-target form ignores bits 15:0.

All results are registered. They appear one clock after the strobe, together with a one-cycle output valid.

Top module: `branch_resolve`

## Requirements
- R1: During and directly after synchronous reset, `res_valid` and `res_ctr_we` are 0.
- R2: `res_valid` is 1 in exactly the cycle after a cycle with `req_valid` high, and 0 otherwise; all results are presented in that same cycle.
- R3: Opcode 18 with bit 1 clear is always taken; the target is `req_pc` plus bits 25:2 shifted left by two and sign-extended from result bit 25.
- R4: Opcode 18 with bit 1 set is always taken; the target is that sign-extended offset by itself, with the PC not added.
- R5: For opcode 16, the offset is bits 15:2 shifted left by two and sign-extended from result bit 15. With bit 1 clear the target is `req_pc` plus the offset; with bit 1 set the target is the offset alone.
- R6: For opcode 19, the target is `req_tgt` with its two low bits forced to 0.
- R7: In conditional forms, when options bit 2 is 1 the count test passes and `res_ctr_we` is 0.
- R8: In conditional forms, when options bit 2 is 0, `res_ctr` is `req_ctr` minus 1 (modulo 2^32) and `res_ctr_we` is 1, whether or not the branch is taken. If options bit 1 is 0, the count test passes when the decremented value is nonzero. If options bit 1 is 1, it passes when the decremented value is zero.
- R9: In conditional forms, when options bit 4 is 1 the condition test passes. Otherwise it passes when `req_cr[31 - index]` equals options bit 3. A conditional branch is taken only when both tests pass.
- R10: A branch that is not taken gives `res_next_pc` = `req_pc` + 4.
- R11: Any other opcode is not taken, gives `req_pc` + 4 and leaves `res_ctr_we` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_instr | input | 32 | Branch instruction word |
| req_pc | input | 32 | Address of the instruction |
| req_cr | input | 32 | Condition register |
| req_ctr | input | 32 | Count register |
| req_tgt | input | 32 | Indirect target register |
| res_valid | output | 1 | Result valid, one cycle after request |
| res_taken | output | 1 | Branch taken |
| res_next_pc | output | 32 | Address of the next instruction |
| res_ctr | output | 32 | Decremented count value |
| res_ctr_we | output | 1 | Count write enable |

## Verification
Every result, including the taken flag, the next address, the count value and its enable, is due exactly one clock after the strobe. All of them appear in the same cycle as `res_valid`. The driver applies each request on a falling edge and queues the expected result. The monitor samples 1 ns after every rising edge. It compares a queued entry only when `res_valid` is high, and it flags a queued entry that has no matching valid in that cycle, which checks the latency. The stimulus includes back-to-back requests, both ends of the condition index, and a count value that wraps from 0 to all ones.

// File: rtl/brres_pkg.sv
`timescale 1ns/1ps
package brres_pkg;
    localparam int XW      = 32;
    localparam int OPC_HI  = 31;
    localparam int OPC_W   = 6;
    localparam int BO_W    = 5;
    localparam int BI_W    = 5;
    localparam int LI_W    = 24;
    localparam int BD_W    = 14;
    localparam int STEP    = 4;

    localparam logic [OPC_W-1:0] OPC_UNCOND = 6'd18;
    localparam logic [OPC_W-1:0] OPC_COND   = 6'd16;
    localparam logic [OPC_W-1:0] OPC_REG    = 6'd19;

    typedef enum logic [2:0] {
        FORM_NONE,
        FORM_UNC_REL,
        FORM_UNC_ABS,
        FORM_CND_REL,
        FORM_CND_ABS,
        FORM_CND_REG
    } form_e;

    typedef struct packed {
        form_e           form;
        logic [BO_W-1:0] bo;
        logic [BI_W-1:0] bi;
        logic [XW-1:0]   offset;
    } dec_t;

    typedef struct packed {
        logic          taken;
        logic [XW-1:0] next_pc;
        logic [XW-1:0] ctr;
        logic          ctr_we;
    } res_t;

    function automatic logic [XW-1:0] widen_long(input logic [LI_W-1:0] f);
        return {{(XW-LI_W-2){f[LI_W-1]}}, f, 2'b00};
    endfunction

    function automatic logic [XW-1:0] widen_short(input logic [BD_W-1:0] f);
        return {{(XW-BD_W-2){f[BD_W-1]}}, f, 2'b00};
    endfunction

    function automatic logic is_cond(input form_e f);
        return (f == FORM_CND_REL) || (f == FORM_CND_ABS) || (f == FORM_CND_REG);
    endfunction
endpackage

// File: rtl/brres_decode.sv
`timescale 1ns/1ps
module brres_decode
    import brres_pkg::*;
(
    input  logic [XW-1:0] instr,
    output dec_t          dec
);
    logic [OPC_W-1:0] opc;
    logic             abs_sel;
    logic             unused_link;

    assign opc         = instr[OPC_HI -: OPC_W];
    assign abs_sel     = instr[1];
    assign unused_link = instr[0];

    always_comb begin
        dec.bo     = instr[25:21];
        dec.bi     = instr[20:16];
        dec.offset = '0;
        dec.form   = FORM_NONE;
        unique case (opc)
            OPC_UNCOND: begin
                dec.form   = abs_sel ? FORM_UNC_ABS : FORM_UNC_REL;
                dec.offset = widen_long(instr[25:2]);
            end
            OPC_COND: begin
                dec.form   = abs_sel ? FORM_CND_ABS : FORM_CND_REL;
                dec.offset = widen_short(instr[15:2]);
            end
            OPC_REG: begin
                dec.form   = FORM_CND_REG;
            end
            default: begin
                dec.form   = FORM_NONE;
            end
        endcase
    end
endmodule

// File: rtl/brres_test.sv
`timescale 1ns/1ps
module brres_test
    import brres_pkg::*;
(
    input  form_e           form,
    input  logic [BO_W-1:0] bo,
    input  logic [BI_W-1:0] bi,
    input  logic [XW-1:0]   cr,
    input  logic [XW-1:0]   ctr,
    output logic            pass,
    output logic [XW-1:0]   ctr_dec,
    output logic            ctr_we
);
    logic           ctr_ok;
    logic           cond_ok;
    logic [BI_W-1:0] bit_idx;

    assign ctr_dec = ctr - 1'b1;
    assign bit_idx = BI_W'(XW - 1) - bi;

    always_comb begin
        ctr_we = 1'b0;
        ctr_ok = 1'b1;
        if (is_cond(form) && !bo[2]) begin
            ctr_we = 1'b1;
            ctr_ok = bo[1] ? (ctr_dec == '0) : (ctr_dec != '0);
        end
        cond_ok = bo[4] ? 1'b1 : (cr[bit_idx] == bo[3]);
        unique case (form)
            FORM_UNC_REL, FORM_UNC_ABS:               pass = 1'b1;
            FORM_CND_REL, FORM_CND_ABS, FORM_CND_REG: pass = ctr_ok && cond_ok;
            default:                                  pass = 1'b0;
        endcase
    end
endmodule

// File: rtl/brres_target.sv
`timescale 1ns/1ps
module brres_target
    import brres_pkg::*;
(
    input  form_e         form,
    input  logic [XW-1:0] offset,
    input  logic [XW-1:0] pc,
    input  logic [XW-1:0] tgt,
    output logic [XW-1:0] target
);
    always_comb begin
        unique case (form)
            FORM_UNC_REL, FORM_CND_REL: target = pc + offset;
            FORM_UNC_ABS, FORM_CND_ABS: target = offset;
            FORM_CND_REG:               target = {tgt[XW-1:2], 2'b00};
            default:                    target = pc + XW'(STEP);
        endcase
    end
endmodule

// File: rtl/branch_resolve.sv
`timescale 1ns/1ps
module branch_resolve
    import brres_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [31:0]   req_instr,
    input  logic [31:0]   req_pc,
    input  logic [31:0]   req_cr,
    input  logic [31:0]   req_ctr,
    input  logic [31:0]   req_tgt,
    output logic          res_valid,
    output logic          res_taken,
    output logic [31:0]   res_next_pc,
    output logic [31:0]   res_ctr,
    output logic          res_ctr_we
);
    dec_t          dec;
    logic          pass;
    logic [XW-1:0] ctr_dec;
    logic          ctr_we;
    logic [XW-1:0] target;
    res_t          res_d;
    res_t          res_q;
    logic          vld_q;

    brres_decode u_dec (
        .instr (req_instr),
        .dec   (dec)
    );

    brres_test u_test (
        .form    (dec.form),
        .bo      (dec.bo),
        .bi      (dec.bi),
        .cr      (req_cr),
        .ctr     (req_ctr),
        .pass    (pass),
        .ctr_dec (ctr_dec),
        .ctr_we  (ctr_we)
    );

    brres_target u_tgt (
        .form   (dec.form),
        .offset (dec.offset),
        .pc     (req_pc),
        .tgt    (req_tgt),
        .target (target)
    );

    always_comb begin
        res_d.taken   = pass;
        res_d.next_pc = pass ? target : req_pc + XW'(STEP);
        res_d.ctr     = ctr_dec;
        res_d.ctr_we  = ctr_we;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= req_valid;
            if (req_valid) begin
                res_q <= res_d;
            end else begin
                res_q.ctr_we <= 1'b0;
            end
        end
    end

    assign res_valid   = vld_q;
    assign res_taken   = res_q.taken;
    assign res_next_pc = res_q.next_pc;
    assign res_ctr     = res_q.ctr;
    assign res_ctr_we  = res_q.ctr_we;

    logic [OPC_W-1:0] opc_in;
    assign opc_in = req_instr[OPC_HI -: OPC_W];

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> res_valid);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !res_valid);
    a_r7_no_ctr_write: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (opc_in == OPC_COND || opc_in == OPC_REG) && req_instr[23])
        |=> !res_ctr_we);
    a_r8_ctr_decrement: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (opc_in == OPC_COND || opc_in == OPC_REG) && !req_instr[23])
        |=> (res_ctr_we && res_ctr == $past(req_ctr) - 32'd1));
    a_r10_fallthrough: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (res_taken || res_next_pc == $past(req_pc) + 32'd4));
    a_r11_other_opcode: assert property (@(posedge clk) disable iff (rst)
        (req_valid && opc_in != OPC_COND && opc_in != OPC_REG && opc_in != OPC_UNCOND)
        |=> (!res_taken && !res_ctr_we));
    a_r3_uncond_taken: assert property (@(posedge clk) disable iff (rst)
        (req_valid && opc_in == OPC_UNCOND) |=> (res_taken && !res_ctr_we));
endmodule

// File: tb/test_branch_resolve.sv
`timescale 1ns/1ps
module test_branch_resolve;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [31:0] req_instr, req_pc, req_cr, req_ctr, req_tgt;
    logic        res_valid, res_taken, res_ctr_we;
    logic [31:0] res_next_pc, res_ctr;

    always #2.5 clk = ~clk;

    branch_resolve i_branch_resolve (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_instr(req_instr),
        .req_pc(req_pc), .req_cr(req_cr), .req_ctr(req_ctr), .req_tgt(req_tgt),
        .res_valid(res_valid), .res_taken(res_taken), .res_next_pc(res_next_pc),
        .res_ctr(res_ctr), .res_ctr_we(res_ctr_we)
    );

    typedef struct {
        logic        taken;
        logic [31:0] npc;
        logic        we;
        logic [31:0] ctr;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 0;

    function automatic logic [31:0] mk_unc(input logic [23:0] li, input logic aa);
        return {6'd18, li, aa, 1'b0};
    endfunction
    function automatic logic [31:0] mk_cnd(input logic [4:0] bo, input logic [4:0] bi,
                                           input logic [13:0] bd, input logic aa);
        return {6'd16, bo, bi, bd, aa, 1'b0};
    endfunction
    function automatic logic [31:0] mk_reg(input logic [4:0] bo, input logic [4:0] bi);
        return {6'd19, bo, bi, 16'h5a5b};
    endfunction

    function automatic exp_t model(input logic [31:0] ins, input logic [31:0] pc,
                                   input logic [31:0] cr, input logic [31:0] ctr,
                                   input logic [31:0] tg, input string tag);
        exp_t e;
        logic [4:0]  bo;
        logic [4:0]  bi;
        logic [31:0] t;
        logic        c_ok;
        logic        b_ok;
        bo = ins[25:21];
        bi = ins[20:16];
        e.tag = tag;
        e.we = 1'b0;
        e.ctr = 32'h0;
        e.taken = 1'b0;
        t = pc + 32'd4;
        case (ins[31:26])
            6'd18: begin
                e.taken = 1'b1;
                t = {{6{ins[25]}}, ins[25:2], 2'b00};
                if (!ins[1]) t = pc + t;
            end
            6'd16, 6'd19: begin
                c_ok = 1'b1;
                if (!bo[2]) begin
                    e.we = 1'b1;
                    e.ctr = ctr - 32'd1;
                    c_ok = bo[1] ? (e.ctr == 0) : (e.ctr != 0);
                end
                b_ok = bo[4] ? 1'b1 : (cr[31 - bi] == bo[3]);
                e.taken = c_ok && b_ok;
                if (ins[31:26] == 6'd19) t = tg & 32'hFFFF_FFFC;
                else begin
                    t = {{16{ins[15]}}, ins[15:2], 2'b00};
                    if (!ins[1]) t = pc + t;
                end
            end
            default: ;
        endcase
        e.npc = e.taken ? t : pc + 32'd4;
        return e;
    endfunction

    task automatic drive(input logic [31:0] ins, input logic [31:0] pc,
                         input logic [31:0] cr, input logic [31:0] ctr,
                         input logic [31:0] tg, input string tag);
        @(negedge clk);
        req_valid = 1'b1;
        req_instr = ins;
        req_pc    = pc;
        req_cr    = cr;
        req_ctr   = ctr;
        req_tgt   = tg;
        q.push_back(model(ins, pc, cr, ctr, tg, tag));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            req_instr = 32'hFFFF_FFFF;
        end
    endtask

    task automatic chk1(input string tag, input string what, input logic [31:0] act,
                        input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // monitor: results are due one cycle after the strobe (R2)
    always @(posedge clk) begin
        #1;
        if (!rst && !done) begin
            if (res_valid) begin
                if (q.size() == 0) begin
                    chk1("R2", "unexpected valid", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk1(e.tag, "taken", {31'd0, res_taken}, {31'd0, e.taken});
                    chk1(e.tag, "next_pc", res_next_pc, e.npc);
                    chk1(e.tag, "ctr_we", {31'd0, res_ctr_we}, {31'd0, e.we});
                    if (e.we) chk1(e.tag, "ctr", res_ctr, e.ctr);
                end
            end else if (q.size() != 0) begin
                chk1("R2", "missing valid", 32'd0, 32'd1);
                void'(q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        req_valid = 1'b0;
        req_instr = '0; req_pc = '0; req_cr = '0; req_ctr = '0; req_tgt = '0;
        repeat (3) @(posedge clk);
        #1;
        chk1("R1", "valid in reset", {31'd0, res_valid}, 32'd0);
        chk1("R1", "ctr_we in reset", {31'd0, res_ctr_we}, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        chk1("R1", "valid after reset", {31'd0, res_valid}, 32'd0);

        // R3 relative unconditional, positive and negative
        drive(mk_unc(24'h000010, 1'b0), 32'h0000_1000, 0, 7, 0, "R3");
        drive(mk_unc(24'hFFFFF0, 1'b0), 32'h0000_1000, 0, 7, 0, "R3");
        // R4 absolute unconditional, negative offset
        drive(mk_unc(24'h800001, 1'b1), 32'h1234_0000, 0, 7, 0, "R4");
        idle(2);
        // R5 conditional always, relative negative / absolute positive
        drive(mk_cnd(5'b10100, 5'd0, 14'h3FFE, 1'b0), 32'h0000_2000, 0, 9, 0, "R5");
        drive(mk_cnd(5'b10100, 5'd0, 14'h0123, 1'b1), 32'h0000_2000, 0, 9, 0, "R5");
        drive(mk_cnd(5'b10100, 5'd0, 14'h2000, 1'b1), 32'h0000_2000, 0, 9, 0, "R5");
        // R9 condition bit at both ends of the index
        drive(mk_cnd(5'b01100, 5'd0, 14'h0010, 1'b0), 32'h100, 32'h8000_0000, 3, 0, "R9");
        drive(mk_cnd(5'b01100, 5'd31, 14'h0010, 1'b0), 32'h100, 32'h8000_0000, 3, 0, "R9_R10");
        drive(mk_cnd(5'b00100, 5'd31, 14'h0010, 1'b0), 32'h100, 32'h8000_0000, 3, 0, "R9");
        drive(mk_cnd(5'b00100, 5'd0, 14'h0010, 1'b0), 32'h100, 32'h8000_0000, 3, 0, "R9_R10");
        idle(1);
        // R7 count test skipped, no write
        drive(mk_cnd(5'b10100, 5'd4, 14'h0008, 1'b0), 32'h400, 0, 1, 0, "R7");
        // R8 decrement, nonzero required
        drive(mk_cnd(5'b10000, 5'd4, 14'h0008, 1'b0), 32'h400, 0, 5, 0, "R8");
        drive(mk_cnd(5'b10000, 5'd4, 14'h0008, 1'b0), 32'h400, 0, 1, 0, "R8_R10");
        // R8 decrement, zero required, incl. wrap
        drive(mk_cnd(5'b10010, 5'd4, 14'h0008, 1'b0), 32'h400, 0, 1, 0, "R8");
        drive(mk_cnd(5'b10010, 5'd4, 14'h0008, 1'b0), 32'h400, 0, 0, 0, "R8_R10");
        // R8 with condition failing: count still written
        drive(mk_cnd(5'b00000, 5'd2, 14'h0008, 1'b0), 32'h400, 32'h2000_0000, 5, 0, "R8");
        idle(2);
        // R6 register target
        drive(mk_reg(5'b10100, 5'd0), 32'h800, 0, 2, 32'h0000_1237, "R6");
        drive(mk_reg(5'b10000, 5'd0), 32'h800, 0, 2, 32'hABCD_EF03, "R6");
        drive(mk_reg(5'b10010, 5'd0), 32'h800, 0, 2, 32'hABCD_EF03, "R6_R10");
        // R11 other opcodes
        drive({6'd17, 26'h3FF_FFFF}, 32'h900, 32'hFFFF_FFFF, 1, 32'h40, "R11");
        drive({6'd0, 26'h000_0000}, 32'hFFFF_FFFC, 0, 1, 0, "R11");
        idle(4);

        done = 1'b1;
        chk1("R2", "queue drained", q.size(), 32'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule